// File: doc/BRIEF.md
# Buffered Parallel-In Serial-Out Shifter

This block turns a parallel word into a serial bit stream in two stages. A storage register takes a snapshot of the parallel input bus when its own strobe input rises. A separate shift register is filled from that snapshot by a level-sensitive load control. It then moves its contents one place toward the most significant bit on each rising edge of an independent shift strobe, and a serial input fills the vacated least significant bit. The serial output is always the most significant bit of the shift register. Because the snapshot is held in its own register, a new word can be captured while the previous one is still being shifted out.

Both strobe inputs are treated as asynchronous. They pass through synchronisers clocked by the system clock, and only their rising edges are used. The active-low clear and load controls, the serial input and the parallel bus are sampled directly on the system clock. The parallel bus must therefore be held stable until the capture has taken effect. Clear overrides load, and both override a shift.

Top module: `pisoBufferedShifter`

## Requirements
- R1: While system reset `rstN` is low and after it is released, the shift register and the storage register both hold all zeros, so `serOut` is 0 and a load made after reset gives an all-zero word.
- R2: The storage register takes the value of `parIn` only when a rising edge of `storeClk` is detected. Changes on `parIn` at any other time have no effect on what a later load transfers.
- R3: While `loadN` is low and `clearN` is high, every system clock edge copies the storage register into the shift register. `serOut` then shows storage bit 7 on the cycle after that edge.
- R4: Each detected rising edge of `shiftClk` moves bit i of the shift register to bit i+1 and places `serIn` in bit 0. The word therefore leaves on `serOut` most significant bit first, and after 8 shifts `serOut` shows the first serial-input bit that was shifted in.
- R5: While `clearN` is low, the shift register is forced to all zeros. The storage register is unaffected, and a later load still transfers the stored word.
- R6: When `clearN` and `loadN` are both low in the same cycle, the clear wins and the shift register becomes all zeros.
- R7: A load or clear in the same cycle as a detected shift edge overrides the shift. The shift register takes the loaded value, or zero, without any shift applied.
- R8: A storage capture made while a word is being shifted out does not disturb the shift register. The remaining bits leave unchanged.
- R9: When a storage capture and a load fall in the same cycle, the shift register receives the storage value from before that capture.
- R10: Each strobe input acts once per rising edge, however long it stays high. Its falling edge has no effect.
- R11: A rising edge on `storeClk` or `shiftClk` takes effect at the third system clock edge after it, through a two-stage synchroniser plus one edge-detection flop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| parIn | input | 8 | Parallel word to be captured |
| storeClk | input | 1 | Asynchronous capture strobe for the storage register |
| shiftClk | input | 1 | Asynchronous shift strobe for the shift register |
| serIn | input | 1 | Bit entering shift register bit 0 on each shift |
| loadN | input | 1 | Active-low load of the shift register from the storage register |
| clearN | input | 1 | Active-low clear of the shift register |
| serOut | output | 1 | Shift register bit 7 |

## Verification
The storage register has no output of its own. A wrong snapshot therefore shows up only after a load, either directly on `serOut` or spread across the eight following shifts, so the bench reads out every stored word bit by bit. A shift register that stepped too often, stepped in the wrong direction or lost priority to a shift shows up as a wrong `serOut` level within one shift strobe. The synchroniser latency is checked on the exact system clock edge. A capture that leaked into the shift register, or a load that took the new snapshot instead of the old one, is exposed by the next eight-bit readout.

// File: rtl/pisoPkg.sv
`timescale 1ns/1ps
package pisoPkg;
  // Strobes passed from the control to the datapath, valid for one system cycle
  typedef struct packed {
    logic captureStore; // take a snapshot of the parallel bus
    logic clearShift;   // zero the shift register
    logic loadShift;    // copy the snapshot into the shift register
    logic shiftStep;    // advance the shift register by one place
  } shiftStrobes_t;
endpackage

// File: rtl/pisoEdgeSync.sv
`timescale 1ns/1ps
module pisoEdgeSync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic riseOut
);
  localparam int CHAIN_LEN = SYNC_STAGES + 1;

  logic [CHAIN_LEN-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[CHAIN_LEN-2:0], asyncIn};
  end

  assign riseOut = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];

  // R10
  single_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    riseOut |=> !riseOut);
endmodule

// File: rtl/pisoCtrl.sv
`timescale 1ns/1ps
module pisoCtrl
  import pisoPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          storeClk,
  input  logic          shiftClk,
  input  logic          loadN,
  input  logic          clearN,
  output shiftStrobes_t strb
);
  localparam int NUM_STROBES = 2;

  logic [NUM_STROBES-1:0] rawIn;
  logic [NUM_STROBES-1:0] riseSeen;

  assign rawIn = {shiftClk, storeClk};

  for (genvar g = 0; g < NUM_STROBES; g++) begin : gStrobeSync
    pisoEdgeSync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
      .clk     (clk),
      .rstN    (rstN),
      .asyncIn (rawIn[g]),
      .riseOut (riseSeen[g])
    );
  end

  // Priority: clear over load over shift; capture runs independently
  always_comb begin
    strb              = '0;
    strb.captureStore = riseSeen[0];
    if (!clearN)     strb.clearShift = 1'b1;
    else if (!loadN) strb.loadShift  = 1'b1;
    else             strb.shiftStep  = riseSeen[1];
  end

  // R6, R7
  shift_ops_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.clearShift, strb.loadShift, strb.shiftStep}));
endmodule

// File: rtl/pisoDatapath.sv
`timescale 1ns/1ps
module pisoDatapath
  import pisoPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  shiftStrobes_t    strb,
  input  logic [WIDTH-1:0] parIn,
  input  logic             serIn,
  output logic             serOut
);
  localparam int MSB = WIDTH - 1;

  logic [MSB:0] storeReg;
  logic [MSB:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  storeReg <= '0;
    else if (strb.captureStore) storeReg <= parIn;
  end

  // The load reads storeReg before this edge's capture lands
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                shiftReg <= '0;
    else if (strb.clearShift) shiftReg <= '0;
    else if (strb.loadShift)  shiftReg <= storeReg;
    else if (strb.shiftStep)  shiftReg <= {shiftReg[MSB-1:0], serIn};
  end

  assign serOut = shiftReg[MSB];

  // R2
  capture_takes_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.captureStore |=> storeReg == $past(parIn));
  // R2, R5
  store_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.captureStore |=> $stable(storeReg));
  // R5
  clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearShift |=> shiftReg == '0);
  // R9
  load_old_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadShift |=> shiftReg == $past(storeReg));
  // R4
  shift_toward_msb_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftStep |=> shiftReg == {$past(shiftReg[MSB-1:0]), $past(serIn)});
  // R8
  idle_shift_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.clearShift || strb.loadShift || strb.shiftStep) |=> $stable(shiftReg));
endmodule

// File: rtl/pisoBufferedShifter.sv
`timescale 1ns/1ps
module pisoBufferedShifter
  import pisoPkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] parIn,
  input  logic             storeClk,
  input  logic             shiftClk,
  input  logic             serIn,
  input  logic             loadN,
  input  logic             clearN,
  output logic             serOut
);
  shiftStrobes_t strb;

  pisoCtrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .storeClk (storeClk),
    .shiftClk (shiftClk),
    .loadN    (loadN),
    .clearN   (clearN),
    .strb     (strb)
  );

  pisoDatapath #(.WIDTH(WIDTH)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .parIn  (parIn),
    .serIn  (serIn),
    .serOut (serOut)
  );

  // R1
  reset_out_low_chk: assert property (@(posedge clk) !rstN |=> !serOut);
endmodule

// File: tb/pisoBufferedShifter_tb_top.sv
`timescale 1ns/1ps
module pisoBufferedShifter_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] parIn = '0;
  logic       storeClk = 1'b0;
  logic       shiftClk = 1'b0;
  logic       serIn = 1'b0;
  logic       loadN = 1'b1;
  logic       clearN = 1'b1;
  logic       serOut;

  int  checkCount = 0;
  int  failCount  = 0;
  bit  done       = 1'b0;

  // {word, serial-input pattern}; pattern bit 7 is shifted in first
  localparam logic [15:0] VECS [6] = '{16'hA53C, 16'h00FF, 16'hFF00,
                                       16'h8101, 16'h6E92, 16'h1F7B};

  always #2 clk = ~clk;

  pisoBufferedShifter dut_i (
    .clk(clk), .rstN(rstN), .parIn(parIn), .storeClk(storeClk),
    .shiftClk(shiftClk), .serIn(serIn), .loadN(loadN), .clearN(clearN),
    .serOut(serOut)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkBit(input logic act, input logic exp, input string tag);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: serOut=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic storeWord(input logic [7:0] w);
    parIn = w; storeClk = 1'b1; tick(4); storeClk = 1'b0; tick(4);
  endtask

  task automatic loadPulse();
    loadN = 1'b0; tick(1); loadN = 1'b1; tick(1);
  endtask

  task automatic shiftPulse(input logic sin);
    serIn = sin; shiftClk = 1'b1; tick(4); shiftClk = 1'b0; tick(4);
  endtask

  task automatic readOut(input logic [7:0] exp, input string tag);
    for (int i = 0; i < 8; i++) begin
      checkBit(serOut, exp[7-i], tag);
      shiftPulse(1'b0);
    end
  endtask

  initial begin
    // R1: reset state
    tick(3);
    checkBit(serOut, 1'b0, "R1 during reset");
    rstN = 1'b1; tick(2);
    checkBit(serOut, 1'b0, "R1 after reset");
    storeWord(8'hFF);
    rstN = 1'b0; tick(2); rstN = 1'b1; tick(2);
    loadPulse();
    readOut(8'h00, "R1 storage cleared by reset");

    // R3, R4: table of words and serial-input patterns
    for (int v = 0; v < 6; v++) begin
      logic [7:0] w, pat, m;
      w = VECS[v][15:8]; pat = VECS[v][7:0];
      storeWord(w);
      loadPulse();
      m = w;
      checkBit(serOut, m[7], "R3 load shows bit 7");
      for (int i = 0; i < 8; i++) begin
        shiftPulse(pat[7-i]);
        m = {m[6:0], pat[7-i]};
        checkBit(serOut, m[7], "R4 shift order");
      end
    end

    // R2: bus change without a capture edge is ignored
    storeWord(8'hC3);
    parIn = 8'h3C; tick(10);
    loadPulse();
    readOut(8'hC3, "R2 bus ignored without edge");

    // R5: clear zeroes shifter, storage kept
    storeWord(8'h81); loadPulse();
    clearN = 1'b0; tick(1); clearN = 1'b1; tick(1);
    readOut(8'h00, "R5 clear zeroes shifter");
    loadPulse();
    readOut(8'h81, "R5 storage survives clear");

    // R6: clear beats load
    storeWord(8'hFF);
    clearN = 1'b0; loadN = 1'b0; tick(1); clearN = 1'b1; loadN = 1'b1; tick(1);
    readOut(8'h00, "R6 clear over load");

    // R7: load overrides a shift edge in the same cycle
    storeWord(8'h80); loadPulse();
    serIn = 1'b1; shiftClk = 1'b1; tick(2);
    loadN = 1'b0; tick(1); loadN = 1'b1;
    shiftClk = 1'b0; tick(4);
    readOut(8'h80, "R7 load over shift");

    // R7: clear overrides a shift edge in the same cycle
    storeWord(8'hFF); loadPulse();
    serIn = 1'b1; shiftClk = 1'b1; tick(2);
    clearN = 1'b0; tick(1); clearN = 1'b1;
    shiftClk = 1'b0; tick(4);
    readOut(8'h00, "R7 clear over shift");

    // R9: capture and load in the same cycle -> old snapshot
    storeWord(8'hAA);
    parIn = 8'h55; storeClk = 1'b1; tick(2);
    loadN = 1'b0; tick(1); loadN = 1'b1;
    storeClk = 1'b0; tick(4);
    readOut(8'hAA, "R9 load takes old snapshot");
    loadPulse();
    readOut(8'h55, "R9 new snapshot afterwards");

    // R8: capture in the middle of a readout
    storeWord(8'hF0); loadPulse();
    for (int i = 0; i < 8; i++) begin
      if (i == 3) storeWord(8'h0F);
      checkBit(serOut, 8'hF0 >> (7 - i), "R8 capture leaves shifter alone");
      shiftPulse(1'b0);
    end
    loadPulse();
    readOut(8'h0F, "R8 captured word");

    // R10: long high level gives one step, falling edge none
    storeWord(8'h40); loadPulse();
    checkBit(serOut, 1'b0, "R10 loaded");
    serIn = 1'b0; shiftClk = 1'b1; tick(20);
    checkBit(serOut, 1'b1, "R10 one step on long high");
    shiftClk = 1'b0; tick(10);
    checkBit(serOut, 1'b1, "R10 falling edge no step");

    // R11: shift takes effect at the third system edge
    storeWord(8'h80); loadPulse();
    shiftClk = 1'b1; tick(2);
    checkBit(serOut, 1'b1, "R11 not yet after two edges");
    tick(1);
    checkBit(serOut, 1'b0, "R11 applied at third edge");
    shiftClk = 1'b0; tick(4);

    done = 1'b1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checkCount++; failCount++;
      $display("FAIL watchdog: run did not finish, got hung expected done");
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end
endmodule